// File: doc/BRIEF.md
# ECC Correctable-Error Syndrome Logger

This block sits beside a memory controller's ECC checker and keeps a record of correctable errors for software. The checker hands over one half cache line at a time. For each half it presents the syndrome of both quadword pairs in that half, a valid strobe per pair, and a bit that says whether the half is the lower or upper one. A pair has a correctable error when its strobe is high and its syndrome is non-zero. When both pairs qualify, only the lower-ordered pair is kept.

The block has two log slots, each with a flag. The first-error slot takes an event only while its flag is clear. After that, any further event goes to the next-error slot, and only while the next-error flag is clear. Neither slot is overwritten while its flag is set. Software writes a one to a flag to clear it. Clearing a flag lets that slot capture again, but the old syndrome stays readable until a new capture replaces it.

The check results arrive over a valid/ready stream. Ready is high whenever the warm-reset input is inactive, so the block never stalls the checker outside warm reset. During warm reset ready is low and nothing is taken. The log contents and flags survive warm reset. Only the power-on reset clears them.

Top module: `ecc_synd_logger`

## Requirements
- R1: When power-on reset (`por_n` low) is asserted, both flags, both 16-bit syndrome logs and both pair identifiers read zero.
- R2: A pair qualifies only on a beat where `chk_valid` and `chk_ready` are both high, its bit in `pair_vld` is high, and its syndrome is non-zero. An all-zero syndrome, a cleared strobe or a beat with `chk_valid` low records nothing.
- R3: When both pairs of a beat qualify, the syndrome of pair 0 (bits 15:0 of `pair_synd`) is logged. The pair identifier logged is {`chk_upper`, pair index}: 0 = QW0/1, 1 = QW2/3, 2 = QW4/5, 3 = QW6/7.
- R4: A qualifying beat while `first_flag` is clear loads the first-error log and identifier and sets `first_flag` at the same clock edge.
- R5: A qualifying beat while `first_flag` is set and `next_flag` is clear loads the next-error log and identifier and sets `next_flag`.
- R6: While a flag is set and not being cleared, its log and identifier do not change.
- R7: A one on `clr_first` or `clr_next` clears that flag at the next edge and leaves its log unchanged. If a qualifying beat arrives in the same cycle as the clear, the beat is captured into that slot and the flag stays set.
- R8: With both flags clear, two qualifying beats on consecutive cycles go to the first-error log and then to the next-error log.
- R9: While `warm_rst_n` is low, `chk_ready` is low and beats and clears are ignored. Logs, identifiers and flags keep their values through warm reset and after it ends.
- R10: Outside any reset, `chk_ready` is high, so every beat with `chk_valid` high is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| warm_rst_n | input | 1 | Warm reset, active low; blocks intake and keeps the logs |
| chk_valid | input | 1 | Check-result beat is present |
| chk_ready | output | 1 | Block accepts a beat |
| chk_upper | input | 1 | 0 = lower half line (QW0-3), 1 = upper half line (QW4-7) |
| pair_vld | input | 2 | Per-pair syndrome strobes, bit 0 = lower-ordered pair |
| pair_synd | input | 32 | Pair syndromes, pair 0 in bits 15:0 and pair 1 in bits 31:16 |
| clr_first | input | 1 | Write-one clear of the first-error flag |
| clr_next | input | 1 | Write-one clear of the next-error flag |
| first_flag | output | 1 | First correctable error recorded |
| next_flag | output | 1 | Later correctable error recorded |
| first_synd | output | 16 | First-error syndrome log |
| next_synd | output | 16 | Next-error syndrome log |
| first_pair | output | 2 | Quadword-pair identifier of the first-error log |
| next_pair | output | 2 | Quadword-pair identifier of the next-error log |

## Verification
The case that is hardest to reach from the ports is the one where a clear and a qualifying beat arrive on the same edge: the flag has to stay set while the log takes the new syndrome. That case only exists after the slot has already been filled by an earlier beat. The vector table gets there by first filling both slots, then driving `clr_next` and a new beat in the same cycle. Warm reset is reached with both slots full and a non-zero beat plus clears held on the inputs, so that any leakage would change a visible log.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int unsigned DEF_SYND_W = 16;
  localparam int unsigned DEF_NPAIR  = 2;
endpackage

// File: rtl/ecc_pair_select.sv
module ecc_pair_select #(
  parameter int unsigned SYND_W = ecc_log_pkg::DEF_SYND_W,
  parameter int unsigned NPAIR  = ecc_log_pkg::DEF_NPAIR,
  localparam int unsigned IDX_W = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic [NPAIR-1:0]        vld,
  input  logic [NPAIR*SYND_W-1:0] synd,
  output logic                    hit,
  output logic [IDX_W-1:0]        sel_idx,
  output logic [SYND_W-1:0]       sel_synd
);
  // Scan from the highest pair down so the lowest qualifying pair wins.
  always_comb begin
    hit      = 1'b0;
    sel_idx  = '0;
    sel_synd = '0;
    for (int i = NPAIR - 1; i >= 0; i--) begin
      if (vld[i] && (synd[i*SYND_W +: SYND_W] != '0)) begin
        hit      = 1'b1;
        sel_idx  = IDX_W'(i);
        sel_synd = synd[i*SYND_W +: SYND_W];
      end
    end
  end
endmodule

// File: rtl/ecc_log_slot.sv
module ecc_log_slot #(
  parameter int unsigned SYND_W = ecc_log_pkg::DEF_SYND_W,
  parameter int unsigned PID_W  = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              cap,
  input  logic              clr,
  input  logic [SYND_W-1:0] synd_in,
  input  logic [PID_W-1:0]  pid_in,
  output logic              flag,
  output logic [SYND_W-1:0] synd,
  output logic [PID_W-1:0]  pid
);
  // Only power-on reset touches these registers.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flag <= 1'b0;
      synd <= '0;
      pid  <= '0;
    end else if (cap) begin
      flag <= 1'b1;
      synd <= synd_in;
      pid  <= pid_in;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/ecc_synd_logger.sv
module ecc_synd_logger #(
  parameter int unsigned SYND_W = ecc_log_pkg::DEF_SYND_W,
  parameter int unsigned NPAIR  = ecc_log_pkg::DEF_NPAIR,
  localparam int unsigned IDX_W = (NPAIR > 1) ? $clog2(NPAIR) : 1,
  localparam int unsigned PID_W = IDX_W + 1
) (
  input  logic                    clk,
  input  logic                    por_n,
  input  logic                    warm_rst_n,
  input  logic                    chk_valid,
  output logic                    chk_ready,
  input  logic                    chk_upper,
  input  logic [NPAIR-1:0]        pair_vld,
  input  logic [NPAIR*SYND_W-1:0] pair_synd,
  input  logic                    clr_first,
  input  logic                    clr_next,
  output logic                    first_flag,
  output logic                    next_flag,
  output logic [SYND_W-1:0]       first_synd,
  output logic [SYND_W-1:0]       next_synd,
  output logic [PID_W-1:0]        first_pair,
  output logic [PID_W-1:0]        next_pair
);
  logic              hit;
  logic [IDX_W-1:0]  sel_idx;
  logic [SYND_W-1:0] sel_synd;
  logic              evt, clr_f, clr_n, cap_f, cap_n;
  logic [PID_W-1:0]  pid;

  assign chk_ready = warm_rst_n;

  ecc_pair_select #(.SYND_W(SYND_W), .NPAIR(NPAIR)) sel_i (
    .vld(pair_vld), .synd(pair_synd),
    .hit(hit), .sel_idx(sel_idx), .sel_synd(sel_synd)
  );

  assign evt   = chk_valid && chk_ready && hit;
  assign clr_f = clr_first && warm_rst_n;
  assign clr_n = clr_next && warm_rst_n;
  assign pid   = {chk_upper, sel_idx};

  // A clear in the same cycle re-arms the slot for this beat.
  assign cap_f = evt && (!first_flag || clr_f);
  assign cap_n = evt && !cap_f && (!next_flag || clr_n);

  ecc_log_slot #(.SYND_W(SYND_W), .PID_W(PID_W)) first_i (
    .clk(clk), .por_n(por_n), .cap(cap_f), .clr(clr_f),
    .synd_in(sel_synd), .pid_in(pid),
    .flag(first_flag), .synd(first_synd), .pid(first_pair)
  );

  ecc_log_slot #(.SYND_W(SYND_W), .PID_W(PID_W)) next_i (
    .clk(clk), .por_n(por_n), .cap(cap_n), .clr(clr_n),
    .synd_in(sel_synd), .pid_in(pid),
    .flag(next_flag), .synd(next_synd), .pid(next_pair)
  );
endmodule

// File: rtl/ecc_synd_logger_chk.sv
module ecc_synd_logger_chk #(
  parameter int unsigned SYND_W = 16,
  parameter int unsigned PID_W  = 2
) (
  input logic              clk,
  input logic              por_n,
  input logic              warm_rst_n,
  input logic              chk_valid,
  input logic              chk_ready,
  input logic              clr_first,
  input logic              clr_next,
  input logic              first_flag,
  input logic              next_flag,
  input logic [SYND_W-1:0] first_synd,
  input logic [SYND_W-1:0] next_synd,
  input logic [PID_W-1:0]  first_pair,
  input logic [PID_W-1:0]  next_pair
);
  AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!por_n)
    first_flag && !clr_first |=> first_flag && $stable(first_synd) && $stable(first_pair)); // R6
  AST_NEXT_HELD: assert property (@(posedge clk) disable iff (!por_n)
    next_flag && !clr_next |=> next_flag && $stable(next_synd) && $stable(next_pair)); // R6
  AST_WARM_FREEZE: assert property (@(posedge clk) disable iff (!por_n)
    !warm_rst_n |=> $stable(first_flag) && $stable(next_flag)
                    && $stable(first_synd) && $stable(next_synd)); // R9
  AST_WARM_NOT_READY: assert property (@(posedge clk) disable iff (!por_n)
    !warm_rst_n |-> !chk_ready); // R9
  AST_FIRST_NONZERO: assert property (@(posedge clk) disable iff (!por_n)
    $rose(first_flag) |-> first_synd != '0); // R2
  AST_NEXT_NONZERO: assert property (@(posedge clk) disable iff (!por_n)
    $rose(next_flag) |-> next_synd != '0); // R2
  AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!por_n)
    clr_first && warm_rst_n && !chk_valid |=> !first_flag && $stable(first_synd)); // R7
  AST_NEXT_AFTER_FIRST: assert property (@(posedge clk) disable iff (!por_n)
    $rose(next_flag) |-> $past(first_flag)); // R5
endmodule

bind ecc_synd_logger ecc_synd_logger_chk #(.SYND_W(SYND_W), .PID_W(PID_W)) chk_i (
  .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .chk_valid(chk_valid),
  .chk_ready(chk_ready), .clr_first(clr_first), .clr_next(clr_next),
  .first_flag(first_flag), .next_flag(next_flag), .first_synd(first_synd),
  .next_synd(next_synd), .first_pair(first_pair), .next_pair(next_pair)
);

// File: tb/ecc_synd_logger_tb_top.sv
module ecc_synd_logger_tb_top;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, warm_rst_n = 1'b1;
  logic        chk_valid = 1'b0, chk_upper = 1'b0, clr_first = 1'b0, clr_next = 1'b0;
  logic [1:0]  pair_vld = '0;
  logic [31:0] pair_synd = '0;
  logic        chk_ready, first_flag, next_flag;
  logic [15:0] first_synd, next_synd;
  logic [1:0]  first_pair, next_pair;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  ecc_synd_logger dut_i (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .chk_valid(chk_valid),
    .chk_ready(chk_ready), .chk_upper(chk_upper), .pair_vld(pair_vld),
    .pair_synd(pair_synd), .clr_first(clr_first), .clr_next(clr_next),
    .first_flag(first_flag), .next_flag(next_flag), .first_synd(first_synd),
    .next_synd(next_synd), .first_pair(first_pair), .next_pair(next_pair)
  );

  // {clr_f, clr_n, upper, vld[1:0], synd0, synd1, exp ff, exp nf, exp fs, exp ns, exp fp, exp np}
  localparam int NV = 11;
  localparam logic [74:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,2'b00,16'h0000,16'h0000, 1'b0,1'b0,16'h0000,16'h0000,2'd0,2'd0}, // idle
    {1'b0,1'b0,1'b0,2'b11,16'h0000,16'h0000, 1'b0,1'b0,16'h0000,16'h0000,2'd0,2'd0}, // R2 zero synd
    {1'b0,1'b0,1'b0,2'b11,16'h0011,16'h0022, 1'b1,1'b0,16'h0011,16'h0000,2'd0,2'd0}, // R3 R4
    {1'b0,1'b0,1'b1,2'b10,16'h0000,16'h0033, 1'b1,1'b1,16'h0011,16'h0033,2'd0,2'd3}, // R5
    {1'b0,1'b0,1'b0,2'b01,16'h0044,16'h0000, 1'b1,1'b1,16'h0011,16'h0033,2'd0,2'd3}, // R6
    {1'b1,1'b0,1'b0,2'b00,16'h0000,16'h0000, 1'b0,1'b1,16'h0011,16'h0033,2'd0,2'd3}, // R7 clear keeps log
    {1'b0,1'b0,1'b1,2'b11,16'h0055,16'h0066, 1'b1,1'b1,16'h0055,16'h0033,2'd2,2'd3}, // R3 R4 upper
    {1'b0,1'b1,1'b0,2'b01,16'h0077,16'h0000, 1'b1,1'b1,16'h0055,16'h0077,2'd2,2'd0}, // R7 same-cycle
    {1'b1,1'b1,1'b0,2'b00,16'h0000,16'h0000, 1'b0,1'b0,16'h0055,16'h0077,2'd2,2'd0}, // R7
    {1'b0,1'b0,1'b0,2'b10,16'h0099,16'h00aa, 1'b1,1'b0,16'h00aa,16'h0077,2'd1,2'd0}, // R8 a, R2 strobe
    {1'b0,1'b0,1'b1,2'b01,16'h00bb,16'h0000, 1'b1,1'b1,16'h00aa,16'h00bb,2'd1,2'd2}  // R8 b
  };

  task automatic check(input string req, input logic [37:0] act, input logic [37:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [37:0] obs();
    return {first_flag, next_flag, first_synd, next_synd, first_pair, next_pair};
  endfunction

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check("R1 por", obs(), 38'd0);
        por_n = 1'b1;
        @(negedge clk);
        check("R10 ready", {37'd0, chk_ready}, 38'd1);
        for (int k = 0; k < NV; k++) begin
          {clr_first, clr_next, chk_upper, pair_vld, pair_synd[15:0], pair_synd[31:16]} = VEC[k][74:38];
          chk_valid = 1'b1;
          @(negedge clk);
          check($sformatf("R2-table vec %0d", k), obs(), VEC[k][37:0]);
        end
        // R2: chk_valid low ignores a nonzero beat
        clr_first = 1'b1; clr_next = 1'b1; chk_valid = 1'b0;
        @(negedge clk);
        clr_first = 1'b0; clr_next = 1'b0;
        pair_vld = 2'b11; pair_synd = 32'h1234_5678;
        @(negedge clk);
        check("R2 valid low", obs(), {1'b0,1'b0,16'h00aa,16'h00bb,2'd1,2'd2});
        // fill both slots
        chk_valid = 1'b1; chk_upper = 1'b1;
        @(negedge clk);
        pair_synd = 32'h0000_0abc; pair_vld = 2'b01; chk_upper = 1'b0;
        @(negedge clk);
        chk_valid = 1'b0;
        check("R8 refill", obs(), {1'b1,1'b1,16'h5678,16'h0abc,2'd2,2'd0});
        // R9 warm reset with clears and a beat pending
        warm_rst_n = 1'b0; chk_valid = 1'b1; clr_first = 1'b1; clr_next = 1'b1;
        pair_synd = 32'h0000_0fff;
        @(negedge clk);
        check("R9 not ready", {37'd0, chk_ready}, 38'd0);
        @(negedge clk);
        check("R9 hold", obs(), {1'b1,1'b1,16'h5678,16'h0abc,2'd2,2'd0});
        chk_valid = 1'b0; clr_first = 1'b0; clr_next = 1'b0;
        warm_rst_n = 1'b1;
        @(negedge clk);
        check("R9 after", obs(), {1'b1,1'b1,16'h5678,16'h0abc,2'd2,2'd0});
        check("R10 ready back", {37'd0, chk_ready}, 38'd1);
        // R1 power-on reset clears everything
        por_n = 1'b0;
        @(negedge clk);
        check("R1 por again", obs(), 38'd0);
        por_n = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule